// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block is a 4 KB word-addressed control register space for a chip's system controller. Software reaches it through a plain single-cycle bus: a byte offset, write data, a write strobe and a read strobe. A read returns its data, and any access returns an error flag, one cycle after the request. Every 32-bit offset has an access class: read-write, read-only, write-only or unmapped. An access that breaks its class is refused and flagged.

Writes to the ordinary registers are guarded by a lock. Writing a 16-bit unlock key to a dedicated offset opens the space. Writing a different 16-bit key to another offset closes it again. The space comes out of reset closed. One control word raises a single-cycle system reset request when software sets its low bit. Each register loads its own initial value while the block is in reset.

Top module: `syscfg_regfile`

## Requirements
- R1: A write to offset 0x004 whose bits 15:0 equal 0x767B makes the lock status 1. Any other value written there leaves the lock status unchanged.
- R2: A write to offset 0x008 whose bits 15:0 equal 0xDF0D makes the lock status 0. Bits 31:16 of that write are ignored, and any other key value leaves the lock status unchanged.
- R3: After reset the lock status is 1. A read of offset 0x00C returns the lock status in bit 0, with all other bits zero.
- R4: While the lock status is 1, a write to any read-write register other than offset 0x000 is dropped without raising the error flag. The register keeps its previous value.
- R5: Offset 0x000 keeps only bit 0 of the data written to it. It accepts writes whether the space is locked or not.
- R6: While the space is unlocked, a write to a read-write register stores the full 32-bit value, and a later read returns that value.
- R7: An access to an unmapped offset, a read of a write-only offset (0x004, 0x008, 0x60C, 0x614), or a write to a read-only offset raises err for exactly the cycle after the request. Such an access returns zero on rdata and changes no state.
- R8: Reset loads 0x0001A008 into offsets 0x100, 0x104 and 0x108, and 0x00003F03 into offset 0x154.
- R9: An accepted write to offset 0x200 with bit 0 set, made while the space is unlocked, stores the value and drives rst_req high for exactly the next cycle. A write with bit 0 clear, or a write made while the space is locked, produces no pulse.
- R10: rdata and err are registered and valid in the cycle after the request. rdata is zero in every cycle that does not follow an accepted read. When wr_en and rd_en are high together, the access is treated as a write only.
- R11: The read-only offsets (0x00C, 0x10C, 0x17C, 0x18C, 0x19C, 0x1AC, 0x25C, 0x530, 0x618, 0x620) return fixed values: 0x0000003F at 0x10C, 0x00000001 at 0x25C, and zero at the others apart from the lock status. A write to the write-only offsets 0x60C and 0x614 is accepted without error and has no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rdata | output | 32 | Read data, one cycle after the request |
| err | output | 1 | Access refused, one cycle after the request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the key registers with near-miss values and with junk in the upper half-word. A design that compared all 32 bits, or that accepted a neighbouring key, would leave the lock status wrong on the following status read. It writes ordinary registers and the reset-control word while the space is locked. A design that let such writes through would show altered read data or a reset pulse where none is due. It also covers the corner cases of the access classes: reads of write-only keys, writes to read-only status words, unmapped offsets, and a combined read and write strobe. A design that classified any of these wrongly would raise or omit err, or return nonzero data. A mid-run reset confirms that the space locks again and that the initial values come back.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RW   = 2'd1,
        ACC_RO   = 2'd2,
        ACC_WO   = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e cls;
        logic bad;
        logic do_wr;
        logic do_rd;
    } dec_t;

    localparam logic [15:0] KEY_CLOSE = 16'h767B;
    localparam logic [15:0] KEY_OPEN  = 16'hDF0D;

    localparam int OFS_SCRATCH = 'h000;
    localparam int OFS_CLOSE   = 'h004;
    localparam int OFS_OPEN    = 'h008;
    localparam int OFS_STATUS  = 'h00C;
    localparam int OFS_SWRST   = 'h200;

    // Access class of a byte offset; misaligned offsets are never mapped.
    function automatic acc_e acc_class(input int ofs);
        acc_e c;
        c = ACC_NONE;
        if ((ofs & 3) != 0) begin
            c = ACC_NONE;
        end else if (ofs inside {'h004, 'h008, 'h60C, 'h614}) begin
            c = ACC_WO;
        end else if (ofs inside {'h00C, 'h10C, 'h17C, 'h18C, 'h19C, 'h1AC,
                                 'h25C, 'h530, 'h618, 'h620}) begin
            c = ACC_RO;
        end else if (ofs inside {'h000, ['h100:'h108], ['h110:'h1A8], 'h1B8,
                                 'h1C0, 'h1C4, ['h200:'h244], 'h24C, 'h250,
                                 'h258, 'h300, 'h304, ['h440:'h448], 'h600,
                                 'h61C, ['h700:'h7D4], ['h804:'h80C], 'h830,
                                 'h834, 'h900, 'h910, 'hA00, 'hA30, 'hA50,
                                 ['hA60:'hA8C], 'hA90, 'hAA0, 'hAB0,
                                 ['hB00:'hB0C], 'hB14, 'hB18,
                                 ['hB40:'hB74]}) begin
            c = ACC_RW;
        end
        return c;
    endfunction

    // Value a word holds after reset (fixed value for read-only words).
    function automatic logic [31:0] init_value(input int ofs);
        logic [31:0] v;
        case (ofs)
            'h100, 'h104, 'h108: v = 32'h0001_A008;
            'h10C:               v = 32'h0000_003F;
            'h154:               v = 32'h0000_3F03;
            'h25C:               v = 32'h0000_0001;
            default:             v = 32'h0000_0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/syscfg_decode.sv
module syscfg_decode
    import syscfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ofs,
    output dec_t              dec
);
    acc_e cls;
    logic wr_bad;
    logic rd_bad;

    always_comb begin
        cls    = acc_class(int'(ofs));
        // A combined strobe is a write; the read side is ignored.
        wr_bad = wr_en && (cls == ACC_NONE || cls == ACC_RO);
        rd_bad = !wr_en && rd_en && (cls == ACC_NONE || cls == ACC_WO);
        dec.cls   = cls;
        dec.bad   = wr_bad || rd_bad;
        dec.do_wr = wr_en && !wr_bad;
        dec.do_rd = !wr_en && rd_en && !rd_bad;
    end

    always_comb begin
        assert_excl_R10: assert (!(dec.do_wr && dec.do_rd));
    end
endmodule

// File: rtl/syscfg_lock.sv
module syscfg_lock
    import syscfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic        at_close,
    input  logic        at_open,
    input  logic [15:0] key,
    output logic        locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
        end else if (key_wr && at_close && key == KEY_CLOSE) begin
            locked <= 1'b1;
        end else if (key_wr && at_open && key == KEY_OPEN) begin
            locked <= 1'b0;
        end
    end

    assert_close_key_R1: assert property (@(posedge clk) disable iff (rst)
        (key_wr && at_close && key == KEY_CLOSE) |=> locked);
    assert_open_key_R2: assert property (@(posedge clk) disable iff (rst)
        (key_wr && at_open && key == KEY_OPEN) |=> !locked);
    assert_wrong_key_R2: assert property (@(posedge clk) disable iff (rst)
        (!(key_wr && (at_close || at_open))) |=> $stable(locked));
    assert_reset_closed_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> locked);
endmodule

// File: rtl/syscfg_store.sv
module syscfg_store
    import syscfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              locked,
    input  logic [ADDR_W-3:0] idx,
    input  logic [31:0]       wd,
    output logic [31:0]       rd
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int WORDS = 2 ** IDX_W;

    logic [WORDS*32-1:0] flat;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam acc_e CLS = acc_class(i * 4);
        if (CLS == ACC_RW) begin : g_rw
            logic [31:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= init_value(i * 4);
                end else if (we && idx == IDX_W'(i)) begin
                    if (i == OFS_SCRATCH) begin
                        q <= {31'b0, wd[0]};
                    end else begin
                        q <= wd;
                    end
                end
            end
            assign flat[i*32 +: 32] = q;
        end else begin : g_fixed
            assign flat[i*32 +: 32] = init_value(i * 4);
        end
    end

    assign rd = flat[idx*32 +: 32];

    assert_locked_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (we && idx != IDX_W'(OFS_SCRATCH / 4)) |-> !locked);
endmodule

// File: rtl/syscfg_regfile.sv
module syscfg_regfile
    import syscfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              rst_req
);
    localparam int IDX_W = ADDR_W - 2;

    logic [ADDR_W-1:0] ofs;
    logic [IDX_W-1:0]  idx;
    dec_t              dec;
    logic              locked;
    logic              commit;
    logic [31:0]       store_rd;

    assign ofs = addr & ~ADDR_W'(3);
    assign idx = ofs[ADDR_W-1:2];

    syscfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .ofs   (ofs),
        .dec   (dec)
    );

    syscfg_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (dec.do_wr),
        .at_close (int'(ofs) == OFS_CLOSE),
        .at_open  (int'(ofs) == OFS_OPEN),
        .key      (wdata[15:0]),
        .locked   (locked)
    );

    assign commit = dec.do_wr && dec.cls == ACC_RW &&
                    (!locked || int'(ofs) == OFS_SCRATCH);

    syscfg_store #(.ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (commit),
        .locked (locked),
        .idx    (idx),
        .wd     (wdata),
        .rd     (store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            err     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            err     <= dec.bad;
            rst_req <= commit && int'(ofs) == OFS_SWRST && wdata[0];
            if (!dec.do_rd) begin
                rdata <= '0;
            end else if (int'(ofs) == OFS_STATUS) begin
                rdata <= {31'b0, locked};
            end else begin
                rdata <= store_rd;
            end
        end
    end

    assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(wr_en) && int'($past(ofs)) == OFS_SWRST &&
                     $past(wdata[0]) && !$past(locked)));
    assert_err_origin_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(wr_en) || $past(rd_en)));
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> rdata == 32'h0);
    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_en) || $past(wr_en)) |-> rdata == 32'h0);
endmodule

// File: tb/test_syscfg_regfile.sv
module test_syscfg_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        err;
    logic        rst_req;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    syscfg_regfile #(.ADDR_W(12)) i_syscfg_regfile (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .err     (err),
        .rst_req (rst_req)
    );

    // {wr, rd, offset[11:0], wdata[31:0], exp_rdata[31:0], exp_err, exp_rst}
    localparam int NV = 39;
    localparam logic [79:0] VEC [NV] = '{
        {2'b01, 12'h00C, 32'h0, 32'h0000_0001, 2'b00},  // R3 starts locked
        {2'b01, 12'h100, 32'h0, 32'h0001_A008, 2'b00},  // R8
        {2'b01, 12'h104, 32'h0, 32'h0001_A008, 2'b00},  // R8
        {2'b01, 12'h108, 32'h0, 32'h0001_A008, 2'b00},  // R8
        {2'b01, 12'h10C, 32'h0, 32'h0000_003F, 2'b00},  // R11
        {2'b01, 12'h154, 32'h0, 32'h0000_3F03, 2'b00},  // R8
        {2'b01, 12'h25C, 32'h0, 32'h0000_0001, 2'b00},  // R11
        {2'b10, 12'h154, 32'h1234_5678, 32'h0, 2'b00},  // R4 dropped
        {2'b01, 12'h154, 32'h0, 32'h0000_3F03, 2'b00},  // R4
        {2'b10, 12'h000, 32'hFFFF_FFFF, 32'h0, 2'b00},  // R5
        {2'b01, 12'h000, 32'h0, 32'h0000_0001, 2'b00},  // R5
        {2'b10, 12'h008, 32'h0000_DF0E, 32'h0, 2'b00},  // R2 near miss
        {2'b01, 12'h00C, 32'h0, 32'h0000_0001, 2'b00},  // R2
        {2'b10, 12'h008, 32'hABCD_DF0D, 32'h0, 2'b00},  // R2 unlock
        {2'b01, 12'h00C, 32'h0, 32'h0000_0000, 2'b00},  // R2
        {2'b10, 12'h154, 32'h0000_A5A5, 32'h0, 2'b00},  // R6
        {2'b01, 12'h154, 32'h0, 32'h0000_A5A5, 2'b00},  // R6
        {2'b01, 12'h004, 32'h0, 32'h0, 2'b10},          // R7 read WO
        {2'b10, 12'h10C, 32'h0000_0005, 32'h0, 2'b10},  // R7 write RO
        {2'b01, 12'h10C, 32'h0, 32'h0000_003F, 2'b00},  // R11 unchanged
        {2'b01, 12'hFFC, 32'h0, 32'h0, 2'b10},          // R7 unmapped read
        {2'b10, 12'hFFC, 32'h0000_0001, 32'h0, 2'b10},  // R7 unmapped write
        {2'b10, 12'h60C, 32'hFFFF_FFFF, 32'h0, 2'b00},  // R11 WO write ok
        {2'b01, 12'h614, 32'h0, 32'h0, 2'b10},          // R7 read WO
        {2'b11, 12'h154, 32'h0000_BEEF, 32'h0, 2'b00},  // R10 write wins
        {2'b01, 12'h154, 32'h0, 32'h0000_BEEF, 2'b00},  // R10
        {2'b10, 12'h200, 32'h0000_0001, 32'h0, 2'b01},  // R9 pulse
        {2'b01, 12'h200, 32'h0, 32'h0000_0001, 2'b00},  // R9 one cycle
        {2'b10, 12'h200, 32'h0000_0002, 32'h0, 2'b00},  // R9 bit0 clear
        {2'b01, 12'h200, 32'h0, 32'h0000_0002, 2'b00},  // R9
        {2'b10, 12'h004, 32'h0000_767A, 32'h0, 2'b00},  // R1 near miss
        {2'b01, 12'h00C, 32'h0, 32'h0000_0000, 2'b00},  // R1
        {2'b10, 12'h004, 32'hFFFF_767B, 32'h0, 2'b00},  // R1 lock
        {2'b01, 12'h00C, 32'h0, 32'h0000_0001, 2'b00},  // R1
        {2'b10, 12'h200, 32'h0000_0001, 32'h0, 2'b00},  // R9 locked: no pulse
        {2'b01, 12'h200, 32'h0, 32'h0000_0002, 2'b00},  // R4
        {2'b10, 12'h000, 32'hFFFF_FFFE, 32'h0, 2'b00},  // R5 locked write
        {2'b01, 12'h000, 32'h0, 32'h0000_0000, 2'b00},  // R5
        {2'b00, 12'h154, 32'h0, 32'h0, 2'b00}           // R10 idle
    };
    localparam int REQ [NV] = '{3, 8, 8, 8, 11, 8, 11, 4, 4, 5, 5, 2, 2, 2, 2,
                                6, 6, 7, 7, 11, 7, 7, 11, 7, 10, 10, 9, 9, 9,
                                9, 1, 1, 1, 1, 9, 4, 5, 5, 10};

    task automatic op(input logic w, input logic r, input logic [11:0] a,
                      input logic [31:0] d, input logic [31:0] erd,
                      input logic eerr, input logic erst, input int req);
        wr_en = w;
        rd_en = r;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        compared++;
        if (rdata !== erd || err !== eerr || rst_req !== erst) begin
            mismatched++;
            $display("FAIL R%0d ofs=%h: rdata=%h err=%b rst_req=%b, expected rdata=%h err=%b rst_req=%b",
                     req, a, rdata, err, rst_req, erd, eerr, erst);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R3 and R10: quiet outputs after reset
        compared++;
        if (rdata !== 32'h0 || err !== 1'b0 || rst_req !== 1'b0) begin
            mismatched++;
            $display("FAIL R3 reset outputs: rdata=%h err=%b rst_req=%b, expected 0 0 0",
                     rdata, err, rst_req);
        end
        for (int k = 0; k < NV; k++) begin
            op(VEC[k][79], VEC[k][78], VEC[k][77:66], VEC[k][65:34],
               VEC[k][33:2], VEC[k][1], VEC[k][0], REQ[k]);
        end
        // R3 R8: a mid-run reset closes the space and restores initial values
        op(1'b1, 1'b0, 12'h008, 32'h0000_DF0D, 32'h0, 1'b0, 1'b0, 2);
        op(1'b1, 1'b0, 12'h154, 32'h0000_0077, 32'h0, 1'b0, 1'b0, 6);
        op(1'b1, 1'b0, 12'h000, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 5);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        op(1'b0, 1'b1, 12'h00C, 32'h0, 32'h0000_0001, 1'b0, 1'b0, 3);
        op(1'b0, 1'b1, 12'h154, 32'h0, 32'h0000_3F03, 1'b0, 1'b0, 8);
        op(1'b0, 1'b1, 12'h000, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8);
        // R9: back-to-back accepted writes each give a pulse
        op(1'b1, 1'b0, 12'h008, 32'h0000_DF0D, 32'h0, 1'b0, 1'b0, 2);
        op(1'b1, 1'b0, 12'h200, 32'h0000_0003, 32'h0, 1'b0, 1'b1, 9);
        op(1'b1, 1'b0, 12'h200, 32'h0000_0001, 32'h0, 1'b0, 1'b1, 9);
        op(1'b0, 1'b0, 12'h000, 32'h0, 32'h0, 1'b0, 1'b0, 9);
        // R7: misaligned offset inside a mapped word still decodes to it
        op(1'b0, 1'b1, 12'h157, 32'h0, 32'h0000_3F03, 1'b0, 1'b0, 7);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule